// File: doc/BRIEF.md
# Rate-Selectable Up/Down Event Timer

This block is a free-running time base for one channel. It advances a 24-bit count on sample-clock pulses that have been divided down by a rate picked from a 4-bit mode code. The same code also picks whether the count goes up or down. Capture and compare logic elsewhere on the chip reads the count to stamp and schedule events. A one-cycle tick strobe marks each cycle in which the count steps.

The sample clock arrives as a one-cycle enable, `smp_en`, inside the system clock domain. Code values with the top bit clear are not timer modes. In those modes the count stays frozen. Code values with the top bit set run the timer:

- bit 2 selects the direction: 0 counts up, 1 counts down.
- bits 1:0 select the divider: 00 and 01 divide by ten, 10 divides by five, 11 divides by two and a half.

The two-and-a-half divider alternates prescaler periods of 2 and 3 samples. A synchronous load writes any start value into the count. All ports are plain control and status pins. Nothing here carries a stream, so there is no handshake and no back-pressure.

Top module: `evt_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released with no further stimulus, `cnt` is 0 and `tick` is 0.
- R2: With `mode_code` 8 to 11 each tick adds one to `cnt`; with codes 12 to 15 each tick subtracts one.
- R3: Codes 8, 9, 12 and 13 raise a tick on every 10th sample after the prescaler restarts.
- R4: Codes 10 and 14 raise a tick on every 5th sample after the prescaler restarts.
- R5: Codes 11 and 15 raise ticks on samples 2, 5, 7, 10, 12 and so on after a restart. The gaps alternate 2 and 3, starting with 2.
- R6: Codes 0 to 7 leave `cnt` unchanged and raise no tick, however many samples arrive.
- R7: `cnt` wraps modulo 2^24: 0xFFFFFF plus one is 0, and 0 minus one is 0xFFFFFF.
- R8: A sample on which `mode_code` differs from its value at the previous sample restarts the prescaler and raises no tick. The first tick at the new rate therefore comes one full divided period after that sample.
- R9: `load` in any cycle sets `cnt` to `load_val` at the next clock edge and raises no tick in that cycle. `load` also restarts the prescaler. A tick that would have fallen on that edge is dropped.
- R10: Clock edges with `smp_en` low do not advance the prescaler or the count.
- R11: `tick` is high for exactly one clock cycle. `cnt` changes in that same cycle, and at no other time except after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | One-cycle sample-clock pulse |
| mode_code | input | 4 | Direction and divide-rate select |
| load | input | 1 | Synchronous load of the count |
| load_val | input | 24 | Value written by `load` |
| cnt | output | 24 | Current timer count |
| tick | output | 1 | Pulse in each cycle the count steps |

## Verification
The hardest state to reach from the ports is the prescaler sitting one sample short of a tick at the moment a mode change or a load arrives. In that state the expected tick must be dropped and the new period must start from zero. The stimulus reaches it by loading to restart the prescaler, then issuing exactly one sample fewer than the period before switching the code or asserting `load` on the next sample. Sparse enables, with idle clocks between samples, show that only `smp_en` drives the prescaler.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'd0,
    RATE_MID  = 2'd1,
    RATE_FRAC = 2'd2
  } rate_e;

  typedef struct packed {
    logic  run;
    logic  down;
    rate_e rate;
  } tmode_t;

  function automatic tmode_t decode_code(input logic [3:0] code);
    tmode_t m;
    m.run  = code[3];
    m.down = code[2];
    case (code[1:0])
      2'b11:   m.rate = RATE_FRAC;
      2'b10:   m.rate = RATE_MID;
      default: m.rate = RATE_SLOW;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/evt_timer_dec.sv
module evt_timer_dec
  import evt_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic [3:0] code,
  output tmode_t     mode,
  output logic       resync
);

  logic [3:0] code_q;

  assign mode   = decode_code(code);
  assign resync = smp_en && (code != code_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      code_q <= '0;
    else if (smp_en) code_q <= code;
  end

endmodule

// File: rtl/evt_timer_pre.sv
module evt_timer_pre
  import evt_timer_pkg::*;
#(
  parameter int SLOW_DIV   = 10,
  parameter int MID_DIV    = 5,
  parameter int FRAC_SHORT = 2,
  parameter int FRAC_LONG  = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp_en,
  input  logic   clear,
  input  logic   resync,
  input  tmode_t mode,
  output logic   fire
);

  localparam int MAX_A  = (SLOW_DIV > MID_DIV) ? SLOW_DIV : MID_DIV;
  localparam int MAX_B  = (FRAC_SHORT > FRAC_LONG) ? FRAC_SHORT : FRAC_LONG;
  localparam int MAX_DV = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PW     = (MAX_DV > 2) ? $clog2(MAX_DV) : 1;

  logic [PW-1:0] pre_q;
  logic          phase_q;
  logic [PW-1:0] last;
  logic          hit;

  always_comb begin
    case (mode.rate)
      RATE_MID:  last = PW'(MID_DIV - 1);
      RATE_FRAC: last = phase_q ? PW'(FRAC_LONG - 1) : PW'(FRAC_SHORT - 1);
      default:   last = PW'(SLOW_DIV - 1);
    endcase
  end

  assign hit  = (pre_q == last);
  assign fire = smp_en && mode.run && !clear && !resync && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      phase_q <= 1'b0;
    end else if (clear) begin
      pre_q   <= '0;
      phase_q <= 1'b0;
    end else if (smp_en) begin
      if (resync || !mode.run) begin
        pre_q   <= '0;
        phase_q <= 1'b0;
      end else if (hit) begin
        pre_q   <= '0;
        phase_q <= (mode.rate == RATE_FRAC) ? !phase_q : 1'b0;
      end else begin
        pre_q   <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  output logic [W-1:0] cnt,
  output logic         tick
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      tick <= 1'b0;
    end else if (step) begin
      cnt  <= down ? cnt - 1'b1 : cnt + 1'b1;
      tick <= 1'b1;
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int SLOW_DIV   = 10,
  parameter int MID_DIV    = 5,
  parameter int FRAC_SHORT = 2,
  parameter int FRAC_LONG  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic [3:0]       mode_code,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);

  tmode_t mode;
  logic   resync;
  logic   fire;

  evt_timer_dec u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (smp_en),
    .code   (mode_code),
    .mode   (mode),
    .resync (resync)
  );

  evt_timer_pre #(
    .SLOW_DIV   (SLOW_DIV),
    .MID_DIV    (MID_DIV),
    .FRAC_SHORT (FRAC_SHORT),
    .FRAC_LONG  (FRAC_LONG)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (smp_en),
    .clear  (load),
    .resync (resync),
    .mode   (mode),
    .fire   (fire)
  );

  evt_timer_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .step     (fire),
    .down     (mode.down),
    .cnt      (cnt),
    .tick     (tick)
  );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   mode_code,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic [W-1:0] cnt,
  input logic         tick
);

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(mode_code[3]) && !$past(load)); // R6

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !$past(mode_code[2])) |-> cnt == $past(cnt) + 1'b1); // R2

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(mode_code[2])) |-> cnt == $past(cnt) - 1'b1); // R2

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !$past(mode_code[2]) && $past(cnt) == {W{1'b1}}) |-> cnt == '0); // R7

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (cnt == $past(load_val)) && !tick); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !$past(load)) |-> $stable(cnt)); // R11

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R11

endmodule

bind evt_timer evt_timer_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_code (mode_code),
  .load      (load),
  .load_val  (load_val),
  .cnt       (cnt),
  .tick      (tick)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

  localparam int CLK_P = 10;
  localparam int W     = 24;
  localparam int NV    = 8;

  typedef struct packed {
    logic [3:0]   code;
    logic [W-1:0] start;
    logic [7:0]   nsmp;
    logic [1:0]   gap;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{code: 4'd8,  start: 24'd100,  nsmp: 8'd35, gap: 2'd0},
    '{code: 4'd9,  start: 24'd0,    nsmp: 8'd20, gap: 2'd1},
    '{code: 4'd10, start: 24'd5000, nsmp: 8'd17, gap: 2'd0},
    '{code: 4'd11, start: 24'd7,    nsmp: 8'd12, gap: 2'd2},
    '{code: 4'd12, start: 24'd1000, nsmp: 8'd40, gap: 2'd0},
    '{code: 4'd13, start: 24'd50,   nsmp: 8'd9,  gap: 2'd1},
    '{code: 4'd14, start: 24'd9,    nsmp: 8'd26, gap: 2'd0},
    '{code: 4'd15, start: 24'd20,   nsmp: 8'd13, gap: 2'd3}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_en = 1'b0;
  logic [3:0]   mode_code = 4'd0;
  logic         load = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] cnt;
  logic         tick;

  int n_chk = 0;
  int n_bad = 0;
  int ticks_seen = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evt_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .mode_code (mode_code),
    .load      (load),
    .load_val  (load_val),
    .cnt       (cnt),
    .tick      (tick)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic en);
    smp_en = en;
    @(posedge clk);
    #1;
    if (tick) ticks_seen++;
    @(negedge clk);
  endtask

  task automatic do_load(input logic [3:0] code, input logic [W-1:0] val);
    mode_code = code;
    load_val  = val;
    load      = 1'b1;
    step(1'b1);
    load      = 1'b0;
    ticks_seen = 0;
  endtask

  function automatic int exp_ticks(input logic [3:0] code, input int n);
    case (code[1:0])
      2'b11:   return 2 * (n / 5) + (((n % 5) >= 2) ? 1 : 0);
      2'b10:   return n / 5;
      default: return n / 10;
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step(1'b1);
    check(cnt == '0 && tick == 1'b0, "R1 in reset", {cnt, tick}, 0);
    rst_n = 1'b1;
    repeat (2) step(1'b0);
    check(cnt == '0 && tick == 1'b0, "R1 after release", {cnt, tick}, 0);

    // Table walk: R2 direction, R3/R4/R5 rates, R10 idle clocks between samples
    for (int i = 0; i < NV; i++) begin
      int et;
      logic [W-1:0] ec;
      do_load(VEC[i].code, VEC[i].start);
      for (int s = 0; s < int'(VEC[i].nsmp); s++) begin
        step(1'b1);
        for (int g = 0; g < int'(VEC[i].gap); g++) step(1'b0);
      end
      et = exp_ticks(VEC[i].code, int'(VEC[i].nsmp));
      ec = VEC[i].code[2] ? VEC[i].start - W'(et) : VEC[i].start + W'(et);
      check(ticks_seen == et, "R3/R4/R5 tick count", ticks_seen, et);
      check(cnt == ec, "R2 count after run", cnt, ec);
    end

    // R6: non-timer code holds and raises no tick
    do_load(4'd5, 24'h123);
    repeat (30) step(1'b1);
    check(cnt == 24'h123, "R6 count held", cnt, 24'h123);
    check(ticks_seen == 0, "R6 no tick", ticks_seen, 0);

    // R7: wrap up and down
    do_load(4'd11, 24'hFFFFFF);
    repeat (2) step(1'b1);
    check(cnt == 24'h0, "R7 up wrap", cnt, 0);
    do_load(4'd15, 24'h0);
    repeat (2) step(1'b1);
    check(cnt == 24'hFFFFFF, "R7 down wrap", cnt, 24'hFFFFFF);

    // R8: change code one sample before a tick would fire
    do_load(4'd8, 24'd0);
    repeat (9) step(1'b1);
    mode_code = 4'd10;
    step(1'b1);
    check(tick == 1'b0 && cnt == 24'd0, "R8 no tick on change", cnt, 0);
    repeat (4) step(1'b1);
    check(cnt == 24'd0, "R8 full period pending", cnt, 0);
    step(1'b1);
    check(tick == 1'b1 && cnt == 24'd1, "R8 first tick at new rate", cnt, 1);
    step(1'b0);
    check(tick == 1'b0 && cnt == 24'd1, "R11 tick one cycle", {cnt, tick}, 2);

    // R9: load on the sample that would have ticked
    do_load(4'd10, 24'd10);
    repeat (4) step(1'b1);
    load_val = 24'd500;
    load = 1'b1;
    step(1'b1);
    load = 1'b0;
    check(cnt == 24'd500 && tick == 1'b0, "R9 load wins", cnt, 500);
    repeat (4) step(1'b1);
    check(cnt == 24'd500, "R9 prescaler restarted", cnt, 500);
    step(1'b1);
    check(cnt == 24'd501, "R9 tick after restart", cnt, 501);

    // R10: idle clocks do not advance the prescaler
    do_load(4'd10, 24'd0);
    repeat (4) step(1'b1);
    repeat (20) step(1'b0);
    check(cnt == 24'd0 && ticks_seen == 0, "R10 idle no step", cnt, 0);
    step(1'b1);
    check(cnt == 24'd1, "R10 step on next sample", cnt, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule